// File: doc/BRIEF.md
# Fuse Access Strobe Timing Sequencer

This block drives the timed control pulses for a single access to a one-time-programmable fuse array. A controller issues either a sense (read) request or a program request. The block then takes the cycle counts it needs from a packed timing word: a relax count, a read-strobe count and a program-strobe count. It raises a strobe window made of a leading relax period, an active pulse and a trailing relax period. After that it closes the access with a one-cycle completion pulse, which the controller uses to clear its busy indication.

Each strobe count already includes both relax periods. The length of the active pulse is therefore the strobe count plus one, less twice the relax period, and it never falls below one cycle. A program access adds a fixed postamble after the trailing relax period, with the strobe low and busy still high. The timing word is captured when a request is accepted, so software may rewrite it while an access is in flight. Everything runs on the system clock with a synchronous active-high reset.

Top module: `fuse_strobe_seq`

## Requirements
- R1: While reset is high and in the first cycle after it, busy, strobe, fire and done are all low.
- R2: The timing word holds the program-strobe count in bits [11:0], the relax count in bits [15:12] and the read-strobe count in bits [21:16]. A sense access times its active pulse from the read-strobe field and a program access from the program-strobe field.
- R3: The strobe output is high for one unbroken window. That window is relax+1 cycles with fire low, then the active pulse with fire high, then relax+1 cycles with fire low. Fire is never high outside the strobe window.
- R4: The active pulse lasts (S+1) − 2·(relax+1) cycles, where S is the selected strobe count, and lasts one cycle whenever that value is below one.
- R5: Busy rises in the cycle after a request is sampled and stays high without a gap until the access completes. Done is high for exactly one cycle, the first cycle in which busy is low again.
- R6: A program access holds busy high with strobe low for POST_CYCLES (default 3) cycles between the trailing relax period and done. A sense access goes from the trailing relax period straight to done.
- R7: The timing word is sampled only in the cycle a request is accepted. Changes made while an access runs do not alter its phase lengths.
- R8: A request of either kind that arrives while busy or done is high is ignored. It neither starts nor stretches an access.
- R9: If sense and program requests are sampled in the same idle cycle, a sense access is performed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| timing_word | input | 22 | Packed relax, read-strobe and program-strobe counts |
| req_sense | input | 1 | Start a sense access (sampled when idle) |
| req_prog | input | 1 | Start a program access (sampled when idle) |
| busy | output | 1 | High from acceptance until the access completes |
| strobe | output | 1 | Strobe window including both relax periods |
| fire | output | 1 | Active part of the strobe window |
| done | output | 1 | One-cycle completion pulse |

## Verification
A wrong phase state or a miscounted phase counter appears at the ports within one access. It shows as a leading or trailing relax run of the wrong length, an active pulse of the wrong length, a postamble on the wrong kind of access, or a done pulse that does not line up with the fall of busy. The bench therefore measures every run length cycle by cycle. It checks the cases where the active length is clamped, equals the boundary, or is one above it. A field taken from the wrong bit positions, or a timing word that is not captured at the start, changes the measured lengths of the very access being checked. A request that is not ignored shows up as extra busy cycles, either during the access or right after it.

// File: rtl/fseq_pkg.sv
package fseq_pkg;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_LEAD  = 3'd1,
    PH_ACT   = 3'd2,
    PH_TRAIL = 3'd3,
    PH_POST  = 3'd4,
    PH_DONE  = 3'd5
  } phase_t;

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/fseq_capture.sv
module fseq_capture #(
  parameter int PROG_W  = 12,
  parameter int RELAX_W = 4,
  parameter int READ_W  = 6,
  parameter int CW      = 13
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              load,
  input  logic                              sel_prog,
  input  logic                              busy_now,
  input  logic [PROG_W+RELAX_W+READ_W-1:0]  timing_word,
  output logic [CW-1:0]                     live_relax_m1,
  output logic [CW-1:0]                     relax_m1,
  output logic [CW-1:0]                     act_m1
);
  localparam int RELAX_LSB = PROG_W;
  localparam int READ_LSB  = PROG_W + RELAX_W;

  logic [RELAX_W-1:0] f_relax;
  logic [PROG_W-1:0]  f_prog;
  logic [READ_W-1:0]  f_read;
  logic [RELAX_W-1:0] relax_q;
  logic [CW-1:0]      strobe_q;
  logic [CW-1:0]      strobe_sel;
  logic [CW-1:0]      span;
  logic [CW-1:0]      both_relax;

  // Field extraction from the packed word
  assign f_prog  = timing_word[PROG_W-1:0];
  assign f_relax = timing_word[RELAX_LSB +: RELAX_W];
  assign f_read  = timing_word[READ_LSB +: READ_W];

  assign strobe_sel    = sel_prog ? CW'(f_prog) : CW'(f_read);
  assign live_relax_m1 = CW'(f_relax);

  // Captured once per access
  always_ff @(posedge clk) begin
    if (rst) begin
      relax_q  <= '0;
      strobe_q <= '0;
    end else if (load) begin
      relax_q  <= f_relax;
      strobe_q <= strobe_sel;
    end
  end

  assign relax_m1   = CW'(relax_q);
  assign span       = strobe_q + CW'(1);
  assign both_relax = (CW'(relax_q) + CW'(1)) << 1;

  // Active length minus one, clamped to a single cycle
  always_comb begin
    if (span > both_relax)
      act_m1 = span - both_relax - CW'(1);
    else
      act_m1 = '0;
  end

  // R7: captured counts hold still for the whole access
  assert_capture_held_R7: assert property (@(posedge clk) disable iff (rst)
    (busy_now && !load) |=> ($stable(relax_q) && $stable(strobe_q)));

endmodule

// File: rtl/fseq_counter.sv
module fseq_counter #(
  parameter int CW = 13
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          at_zero
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)
      cnt_q <= '0;
    else if (load)
      cnt_q <= load_val;
    else if (cnt_q != '0)
      cnt_q <= cnt_q - CW'(1);
  end

  assign at_zero = (cnt_q == '0);

  // Counter only moves downward unless reloaded
  assert_count_down_R3: assert property (@(posedge clk) disable iff (rst)
    (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - CW'(1)));

endmodule

// File: rtl/fseq_ctrl.sv
module fseq_ctrl
  import fseq_pkg::*;
#(
  parameter int CW          = 13,
  parameter int POST_CYCLES = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_sense,
  input  logic          req_prog,
  input  logic          cnt_zero,
  input  logic [CW-1:0] live_relax_m1,
  input  logic [CW-1:0] relax_m1,
  input  logic [CW-1:0] act_m1,
  output logic          cap_load,
  output logic          sel_prog,
  output logic          cnt_load,
  output logic [CW-1:0] cnt_val,
  output logic          busy,
  output logic          strobe,
  output logic          fire,
  output logic          done
);
  localparam logic [CW-1:0] POST_M1 = (POST_CYCLES > 0) ? CW'(POST_CYCLES - 1) : '0;
  localparam bit HAS_POST = (POST_CYCLES > 0);

  phase_t ph_q, ph_d;
  logic   prog_q, prog_d;

  always_comb begin
    ph_d     = ph_q;
    prog_d   = prog_q;
    cap_load = 1'b0;
    cnt_load = 1'b0;
    cnt_val  = '0;
    sel_prog = !req_sense;
    unique case (ph_q)
      PH_IDLE: begin
        if (req_sense || req_prog) begin
          ph_d     = PH_LEAD;
          prog_d   = !req_sense;
          cap_load = 1'b1;
          cnt_load = 1'b1;
          cnt_val  = live_relax_m1;
        end
      end
      PH_LEAD: begin
        if (cnt_zero) begin
          ph_d     = PH_ACT;
          cnt_load = 1'b1;
          cnt_val  = act_m1;
        end
      end
      PH_ACT: begin
        if (cnt_zero) begin
          ph_d     = PH_TRAIL;
          cnt_load = 1'b1;
          cnt_val  = relax_m1;
        end
      end
      PH_TRAIL: begin
        if (cnt_zero) begin
          if (prog_q && HAS_POST) begin
            ph_d     = PH_POST;
            cnt_load = 1'b1;
            cnt_val  = POST_M1;
          end else begin
            ph_d = PH_DONE;
          end
        end
      end
      PH_POST: begin
        if (cnt_zero) ph_d = PH_DONE;
      end
      PH_DONE: ph_d = PH_IDLE;
      default: ph_d = PH_IDLE;
    endcase
  end

  // State and registered outputs, decoded from the next phase
  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q   <= PH_IDLE;
      prog_q <= 1'b0;
      busy   <= 1'b0;
      strobe <= 1'b0;
      fire   <= 1'b0;
      done   <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      prog_q <= prog_d;
      busy   <= (ph_d == PH_LEAD) || (ph_d == PH_ACT) ||
                (ph_d == PH_TRAIL) || (ph_d == PH_POST);
      strobe <= (ph_d == PH_LEAD) || (ph_d == PH_ACT) || (ph_d == PH_TRAIL);
      fire   <= (ph_d == PH_ACT);
      done   <= (ph_d == PH_DONE);
    end
  end

  assert_fire_in_window_R3: assert property (@(posedge clk) disable iff (rst)
    fire |-> strobe);

  assert_done_single_R5: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_done_after_busy_R5: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy)));

  assert_no_restart_R8: assert property (@(posedge clk) disable iff (rst)
    (ph_q != PH_IDLE && ph_q != PH_LEAD) |=> (ph_q != PH_LEAD));

  assert_sense_no_post_R6: assert property (@(posedge clk) disable iff (rst)
    (ph_q == PH_POST) |-> prog_q);

  assert_outputs_onehot_R3: assert property (@(posedge clk) disable iff (rst)
    $onehot0({done, busy}));

endmodule

// File: rtl/fuse_strobe_seq.sv
module fuse_strobe_seq
  import fseq_pkg::*;
#(
  parameter int PROG_W      = 12,
  parameter int RELAX_W     = 4,
  parameter int READ_W      = 6,
  parameter int POST_CYCLES = 3
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic [PROG_W+RELAX_W+READ_W-1:0] timing_word,
  input  logic                             req_sense,
  input  logic                             req_prog,
  output logic                             busy,
  output logic                             strobe,
  output logic                             fire,
  output logic                             done
);
  localparam int SW = max2(PROG_W, READ_W);
  localparam int CW = max2(max2(SW + 1, RELAX_W + 2), $clog2(POST_CYCLES + 1) + 1);

  logic          cap_load;
  logic          sel_prog;
  logic          cnt_load;
  logic [CW-1:0] cnt_val;
  logic          cnt_zero;
  logic [CW-1:0] live_relax_m1;
  logic [CW-1:0] relax_m1;
  logic [CW-1:0] act_m1;

  fseq_capture #(
    .PROG_W (PROG_W),
    .RELAX_W(RELAX_W),
    .READ_W (READ_W),
    .CW     (CW)
  ) cap_i (
    .clk          (clk),
    .rst          (rst),
    .load         (cap_load),
    .sel_prog     (sel_prog),
    .busy_now     (busy),
    .timing_word  (timing_word),
    .live_relax_m1(live_relax_m1),
    .relax_m1     (relax_m1),
    .act_m1       (act_m1)
  );

  fseq_counter #(.CW(CW)) cnt_i (
    .clk     (clk),
    .rst     (rst),
    .load    (cnt_load),
    .load_val(cnt_val),
    .at_zero (cnt_zero)
  );

  fseq_ctrl #(
    .CW         (CW),
    .POST_CYCLES(POST_CYCLES)
  ) ctrl_i (
    .clk          (clk),
    .rst          (rst),
    .req_sense    (req_sense),
    .req_prog     (req_prog),
    .cnt_zero     (cnt_zero),
    .live_relax_m1(live_relax_m1),
    .relax_m1     (relax_m1),
    .act_m1       (act_m1),
    .cap_load     (cap_load),
    .sel_prog     (sel_prog),
    .cnt_load     (cnt_load),
    .cnt_val      (cnt_val),
    .busy         (busy),
    .strobe       (strobe),
    .fire         (fire),
    .done         (done)
  );

  assert_busy_falls_with_done_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);

endmodule

// File: tb/fuse_strobe_seq_tb_top.sv
`timescale 1ns/1ps
module fuse_strobe_seq_tb_top;
  localparam int POST = 3;

  logic        clk = 1'b0;
  logic        rst;
  logic [21:0] timing_word;
  logic        req_sense;
  logic        req_prog;
  logic        busy, strobe, fire, done;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  fuse_strobe_seq #(.POST_CYCLES(POST)) dut_i (
    .clk(clk), .rst(rst), .timing_word(timing_word),
    .req_sense(req_sense), .req_prog(req_prog),
    .busy(busy), .strobe(strobe), .fire(fire), .done(done)
  );

  function automatic logic [21:0] tw(input int prog, input int relax, input int rd);
    return {6'(rd), 4'(relax), 12'(prog)};
  endfunction

  task automatic chk(input int act, input int exp, input string what);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s: actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  // One access, measured cycle by cycle at the falling edge
  task automatic run(input bit s, input bit p, input logic [21:0] w,
                     input int exp_relax, input int exp_act, input int exp_post,
                     input bit disturb, input string tag);
    int lead = 0, act = 0, trail = 0, post = 0, nbusy = 0, gaps = 0;
    int fire_out = 0, cyc = 0, done_busy = 0;
    bit seen_done = 0, first_busy;
    @(negedge clk);
    timing_word = w; req_sense = s; req_prog = p;
    @(negedge clk);
    req_sense = 0; req_prog = 0;
    first_busy = busy;
    while (!seen_done && cyc < 5000) begin
      if (done) begin seen_done = 1; done_busy = busy; end
      else begin
        if (busy) nbusy++; else gaps++;
        if (fire && !strobe) fire_out++;
        if (strobe && !fire && act == 0) lead++;
        else if (fire) act++;
        else if (strobe) trail++;
        else if (busy) post++;
      end
      if (disturb && cyc == 2) begin
        timing_word = ~w; req_prog = 1; req_sense = 1;
      end
      if (disturb && cyc == 4) begin
        req_prog = 0; req_sense = 0;
      end
      if (!seen_done) begin @(negedge clk); cyc++; end
    end
    chk(first_busy, 1, {tag, " R5 busy in first cycle"});
    chk(seen_done, 1, {tag, " R5 done seen"});
    chk(done_busy, 0, {tag, " R5 busy low with done"});
    chk(gaps, 0, {tag, " R5 busy gaps"});
    chk(lead, exp_relax, {tag, " R3 leading relax"});
    chk(act, exp_act, {tag, " R4 active length"});
    chk(trail, exp_relax, {tag, " R3 trailing relax"});
    chk(fire_out, 0, {tag, " R3 fire outside strobe"});
    chk(post, exp_post, {tag, " R6 postamble"});
    chk(nbusy, 2*exp_relax + exp_act + exp_post, {tag, " R5 busy length"});
    @(negedge clk);
    chk(done, 0, {tag, " R5 done single cycle"});
    for (int k = 0; k < 6; k++) begin
      if (busy) begin chk(busy, 0, {tag, " R8 no extra access"}); break; end
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    rst = 1; req_sense = 0; req_prog = 0; timing_word = tw(40, 1, 9);
    repeat (3) @(negedge clk);
    chk(busy | strobe | fire | done, 0, "R1 outputs low in reset");
    rst = 0;
    @(negedge clk);
    chk(busy | strobe | fire | done, 0, "R1 outputs low after reset");
  endtask

  task automatic t_sense_basic();   // R2 read field, A = 10-4 = 6
    run(1, 0, tw(40, 1, 9), 2, 6, 0, 0, "sense_basic R2");
  endtask
  task automatic t_prog_basic();    // R2 prog field, A = 21-6 = 15, R6 postamble
    run(0, 1, tw(20, 2, 9), 3, 15, POST, 0, "prog_basic R2 R6");
  endtask
  task automatic t_clamp();         // R4 clamp: 3 < 8
    run(1, 0, tw(7, 3, 2), 4, 1, 0, 0, "clamp R4");
  endtask
  task automatic t_equal();         // R4 boundary: 4 == 4
    run(1, 0, tw(7, 1, 3), 2, 1, 0, 0, "equal R4");
  endtask
  task automatic t_above();         // R4 one above boundary
    run(1, 0, tw(7, 1, 5), 2, 2, 0, 0, "above R4");
  endtask
  task automatic t_zero();          // R4 all-zero counts
    run(0, 1, tw(0, 0, 0), 1, 1, POST, 0, "zero R4 R6");
  endtask
  task automatic t_max_relax();     // relax 15: 101-32 = 69
    run(0, 1, tw(100, 15, 3), 16, 69, POST, 0, "max_relax R3");
  endtask
  task automatic t_disturb();       // R7 R8: word and requests change mid-access
    run(1, 0, tw(30, 2, 12), 3, 7, 0, 1, "disturb R7 R8");
  endtask
  task automatic t_both();          // R9: sense wins, 5-2 = 3, no postamble
    run(1, 1, tw(50, 0, 4), 1, 3, 0, 0, "both R9");
  endtask

  initial begin
    t_reset();
    t_sense_basic();
    t_prog_basic();
    t_clamp();
    t_equal();
    t_above();
    t_zero();
    t_max_relax();
    t_disturb();
    t_both();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_checks++; n_errors++;
      $display("FAIL watchdog expired: actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end
endmodule